// File: doc/BRIEF.md
# SPI Flash User-Command Transfer Engine

The block is a memory-mapped SPI master that runs one full-duplex command per software trigger. Software fills a 64-byte data buffer through sixteen 32-bit word registers. It programs the bit count, a data-capture enable, a chip-select hold flag and an SCK divider in a configuration word. It then clears the done flag and writes the start bit. The engine shifts the buffer out on MOSI, most significant bit of each byte first. When capture is enabled it writes each MISO bit back into the buffer position of the bit just sent, so reading the buffer after done returns the received data.

The bus is a plain single-cycle register port with a word address. Writes take effect at the clock edge where `bus_sel` and `bus_wr` are high. Read data is combinational from `bus_addr`. There is no streaming interface at the edge, so no back-pressure applies. The only flow rule is this: while a command is busy, writes to the configuration word and the buffer are dropped.

Register map, byte offsets: 0x00 command, 0x04 configuration, 0x08 status, 0x40 + 4·w buffer word w.
- **Command register.** bit 0 is start and reads 1 while busy. bit 1 is soft reset, write-only.
- **Configuration register.** bits 8:0 hold the bit count minus one. bit 12 enables capture. bit 13 holds chip select. bits 23:16 hold the SCK half-period in clocks, minus one.
- **Status register.** bit 0 is done; a write with bit 0 = 0 clears it. bit 1 is the mode bit; 0 selects master.

Top module: `spi_ucmd_engine`

## Requirements
- R1: After reset the engine is idle. `spi_cs_n` = 1, `spi_sck` = 0, the command register reads 0 and the status register reads 0.
- R2: When idle, buffer word w at offset 0x40 + 4·w reads back the value last written to it. Byte k of the buffer is bits 8·(k mod 4)+7 : 8·(k mod 4) of word k/4.
- R3: A command shifts exactly (bit count field + 1) bits on MOSI. It starts at buffer byte 0 and sends each byte MSB first. The clocking is SPI mode 0: SCK idles low, MOSI changes only on falling SCK, and SCK is low whenever chip select is high.
- R4: With capture enabled, the MISO bit sampled on each rising SCK edge replaces the buffer bit just sent, and bits beyond the count are unchanged. With capture disabled the buffer is unchanged.
- R5: Done (status bit 0) is set in the cycle the command ends and stays set when written with bit 0 = 1. A write with bit 0 = 0 clears it. When completion and a clear fall in the same cycle, completion wins.
- R6: The start bit reads 1 from the start write until done is set. While busy, start writes, configuration writes and buffer writes have no effect.
- R7: Chip select goes low at start and stays low while busy. At the end of the command it is released if the hold bit is 0 and stays low if the hold bit is 1.
- R8: Writing command bit 1 aborts any command in the next cycle, leaving the engine idle with `spi_cs_n` = 1 and `spi_sck` = 0. In a write with both bit 0 and bit 1 set, the reset wins and no command starts.
- R9: With the mode bit (status bit 1) at 1, a start write is ignored and the engine stays idle.
- R10: Each SCK high and low phase lasts (divider field + 1) clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | ADDR_W (5) | Word address (byte offset / 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Chip select, active low |

## Verification
The collision that matters is a start and a soft reset arriving in the same cycle. The bench provokes it with a single command-register write that carries both bit 0 and bit 1 while idle. It judges the outcome from the ports: the command register reads 0, chip select stays high, and the slave model sees no SCK edge. A second overlap is a soft reset issued while a command is still shifting. There the bench expects busy to drop and chip select to rise in the next cycle, and it discards the expected bits that were still pending.

// File: rtl/spi_ucmd_pkg.sv
package spi_ucmd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOW,
    ST_HIGH,
    ST_TAIL
  } shift_state_e;

  // word addresses of the control registers
  localparam int unsigned WA_CMD  = 0;
  localparam int unsigned WA_CFG  = 1;
  localparam int unsigned WA_STAT = 2;

  // configuration field positions
  localparam int unsigned CFG_CAPTURE = 12;
  localparam int unsigned CFG_HOLD    = 13;
  localparam int unsigned CFG_DIV_LSB = 16;

endpackage

// File: rtl/ucmd_tick.sv
module ucmd_tick #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q;

  assign tick = run && (cnt_q == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run || tick) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + DIV_W'(1);
    end
  end

endmodule

// File: rtl/ucmd_shift.sv
module ucmd_shift
  import spi_ucmd_pkg::*;
#(
  parameter int unsigned CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             soft_rst,
  input  logic             tick,
  input  logic [CNT_W-1:0] nbits_m1,
  input  logic             capture_en,
  input  logic             cs_hold,
  input  logic             tx_bit,
  output logic [CNT_W-1:0] tx_pos,
  output logic             rx_we,
  output logic [CNT_W-1:0] rx_pos,
  output logic             rx_bit,
  input  logic             miso,
  output logic             sck,
  output logic             mosi,
  output logic             cs_n,
  output logic             busy,
  output logic             fin
);

  shift_state_e     state_q;
  logic [CNT_W-1:0] idx_q;
  logic [CNT_W-1:0] idx_nxt;
  logic [CNT_W-1:0] tx_idx;

  // stream bit i sits in byte i/8, bit 7-(i mod 8)
  function automatic logic [CNT_W-1:0] flat_pos(input logic [CNT_W-1:0] i);
    return {i[CNT_W-1:3], ~i[2:0]};
  endfunction

  assign idx_nxt = idx_q + CNT_W'(1);
  assign tx_idx  = (state_q == ST_IDLE) ? '0 : idx_nxt;
  assign tx_pos  = flat_pos(tx_idx);
  assign rx_pos  = flat_pos(idx_q);
  assign rx_bit  = miso;
  assign rx_we   = (state_q == ST_LOW) && tick && capture_en && !soft_rst;
  assign busy    = (state_q != ST_IDLE);
  assign fin     = (state_q == ST_TAIL) && tick && !soft_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      sck     <= 1'b0;
      mosi    <= 1'b0;
      cs_n    <= 1'b1;
    end else if (soft_rst) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      sck     <= 1'b0;
      cs_n    <= 1'b1;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q <= ST_LOW;
            idx_q   <= '0;
            cs_n    <= 1'b0;
            mosi    <= tx_bit;
          end
        end
        ST_LOW: begin
          if (tick) begin
            sck     <= 1'b1;
            state_q <= ST_HIGH;
          end
        end
        ST_HIGH: begin
          if (tick) begin
            sck <= 1'b0;
            if (idx_q == nbits_m1) begin
              state_q <= ST_TAIL;
            end else begin
              idx_q   <= idx_nxt;
              mosi    <= tx_bit;
              state_q <= ST_LOW;
            end
          end
        end
        ST_TAIL: begin
          if (tick) begin
            state_q <= ST_IDLE;
            cs_n    <= !cs_hold;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ucmd_regs.sv
module ucmd_regs
  import spi_ucmd_pkg::*;
#(
  parameter int unsigned BUF_WORDS = 16,
  parameter int unsigned DIV_W     = 8,
  parameter int unsigned ADDR_W    = 5,
  parameter int unsigned CNT_W     = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              busy,
  input  logic              fin,
  input  logic              rx_we,
  input  logic [CNT_W-1:0]  rx_pos,
  input  logic              rx_bit,
  input  logic [CNT_W-1:0]  tx_pos,
  output logic              tx_bit,
  output logic              start,
  output logic              soft_rst,
  output logic [CNT_W-1:0]  nbits_m1,
  output logic              capture_en,
  output logic              cs_hold,
  output logic [DIV_W-1:0]  div,
  output logic              mode_q,
  output logic              done_q
);

  localparam int unsigned WIDX_W = $clog2(BUF_WORDS);

  logic [31:0] mem_q [BUF_WORDS];
  logic        wr_en;
  logic        in_buf;
  logic [WIDX_W-1:0] widx;
  logic        wr_cmd, wr_cfg, wr_stat, wr_buf;

  assign wr_en   = bus_sel && bus_wr;
  assign in_buf  = bus_addr[ADDR_W-1];
  assign widx    = bus_addr[WIDX_W-1:0];
  assign wr_cmd  = wr_en && !in_buf && (bus_addr == ADDR_W'(WA_CMD));
  assign wr_cfg  = wr_en && !in_buf && (bus_addr == ADDR_W'(WA_CFG)) && !busy;
  assign wr_stat = wr_en && !in_buf && (bus_addr == ADDR_W'(WA_STAT));
  assign wr_buf  = wr_en && in_buf && !busy;

  assign soft_rst = wr_cmd && bus_wdata[1];
  assign start    = wr_cmd && bus_wdata[0] && !bus_wdata[1] && !busy && !mode_q;

  assign tx_bit = mem_q[tx_pos[CNT_W-1:5]][tx_pos[4:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nbits_m1   <= '0;
      capture_en <= 1'b0;
      cs_hold    <= 1'b0;
      div        <= '0;
    end else if (wr_cfg) begin
      nbits_m1   <= bus_wdata[CNT_W-1:0];
      capture_en <= bus_wdata[CFG_CAPTURE];
      cs_hold    <= bus_wdata[CFG_HOLD];
      div        <= bus_wdata[CFG_DIV_LSB +: DIV_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (wr_stat) begin
        mode_q <= bus_wdata[1];
      end
      if (fin) begin
        done_q <= 1'b1;
      end else if (wr_stat && !bus_wdata[0]) begin
        done_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < BUF_WORDS; w++) begin
        mem_q[w] <= '0;
      end
    end else begin
      if (wr_buf) begin
        mem_q[widx] <= bus_wdata;
      end
      if (rx_we) begin
        mem_q[rx_pos[CNT_W-1:5]][rx_pos[4:0]] <= rx_bit;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (in_buf) begin
      bus_rdata = mem_q[widx];
    end else begin
      unique case (bus_addr)
        ADDR_W'(WA_CMD):  bus_rdata[0] = busy;
        ADDR_W'(WA_CFG): begin
          bus_rdata[CNT_W-1:0]           = nbits_m1;
          bus_rdata[CFG_CAPTURE]         = capture_en;
          bus_rdata[CFG_HOLD]            = cs_hold;
          bus_rdata[CFG_DIV_LSB +: DIV_W] = div;
        end
        ADDR_W'(WA_STAT): bus_rdata[1:0] = {mode_q, done_q};
        default: bus_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/spi_ucmd_engine.sv
module spi_ucmd_engine #(
  parameter int unsigned BUF_WORDS = 16,
  parameter int unsigned DIV_W     = 8,
  localparam int unsigned ADDR_W   = $clog2(2 * BUF_WORDS),
  localparam int unsigned CNT_W    = $clog2(BUF_WORDS * 32)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              spi_sck,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic              spi_cs_n
);

  logic             busy, fin, tick;
  logic             start_pulse, soft_rst;
  logic             rx_we, rx_bit, tx_bit;
  logic [CNT_W-1:0] rx_pos, tx_pos, nbits_m1;
  logic             capture_en, cs_hold, mode_q, done_flag;
  logic [DIV_W-1:0] div;

  ucmd_regs #(
    .BUF_WORDS(BUF_WORDS),
    .DIV_W    (DIV_W),
    .ADDR_W   (ADDR_W),
    .CNT_W    (CNT_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .busy      (busy),
    .fin       (fin),
    .rx_we     (rx_we),
    .rx_pos    (rx_pos),
    .rx_bit    (rx_bit),
    .tx_pos    (tx_pos),
    .tx_bit    (tx_bit),
    .start     (start_pulse),
    .soft_rst  (soft_rst),
    .nbits_m1  (nbits_m1),
    .capture_en(capture_en),
    .cs_hold   (cs_hold),
    .div       (div),
    .mode_q    (mode_q),
    .done_q    (done_flag)
  );

  ucmd_tick #(
    .DIV_W(DIV_W)
  ) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (busy),
    .div  (div),
    .tick (tick)
  );

  ucmd_shift #(
    .CNT_W(CNT_W)
  ) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start_pulse),
    .soft_rst  (soft_rst),
    .tick      (tick),
    .nbits_m1  (nbits_m1),
    .capture_en(capture_en),
    .cs_hold   (cs_hold),
    .tx_bit    (tx_bit),
    .tx_pos    (tx_pos),
    .rx_we     (rx_we),
    .rx_pos    (rx_pos),
    .rx_bit    (rx_bit),
    .miso      (spi_miso),
    .sck       (spi_sck),
    .mosi      (spi_mosi),
    .cs_n      (spi_cs_n),
    .busy      (busy),
    .fin       (fin)
  );

endmodule

// File: rtl/ucmd_checker.sv
module ucmd_checker #(
  parameter int unsigned ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              spi_sck,
  input logic              spi_mosi,
  input logic              spi_cs_n,
  input logic              busy,
  input logic              done_flag,
  input logic              soft_rst,
  input logic              mode_q
);

  logic cmd_start_wr;
  assign cmd_start_wr = bus_sel && bus_wr && (bus_addr == '0) && bus_wdata[0];

  // R7: chip select is asserted for the whole command
  a_r7_cs_low_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !spi_cs_n);

  // R3: SCK idles low whenever chip select is released
  a_r3_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck);

  // R3: MOSI does not move on a rising SCK edge
  a_r3_mosi_stable_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_sck) |-> $stable(spi_mosi));

  // R5: a command that ends without abort leaves done set
  a_r5_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !soft_rst) |=> (busy || done_flag));

  // R8: soft reset leaves the engine idle in the next cycle
  a_r8_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!busy && spi_cs_n && !spi_sck));

  // R9: no start outside master mode
  a_r9_no_start_slave: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_start_wr && mode_q && !busy) |=> !busy);

endmodule

bind spi_ucmd_engine ucmd_checker #(.ADDR_W(ADDR_W)) u_ucmd_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_sel  (bus_sel),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .spi_sck  (spi_sck),
  .spi_mosi (spi_mosi),
  .spi_cs_n (spi_cs_n),
  .busy     (busy),
  .done_flag(done_flag),
  .soft_rst (soft_rst),
  .mode_q   (mode_q)
);

// File: tb/test_spi_ucmd_engine.sv
`timescale 1ns/1ps
module test_spi_ucmd_engine;

  localparam int A_CMD = 0, A_CFG = 1, A_STAT = 2, A_BUF = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        spi_sck, spi_mosi, spi_cs_n;
  logic        spi_miso = 1'b0;

  int nvec = 0, nbad = 0;
  bit finished = 0;
  logic [7:0] mdl [64];
  bit exp_q [$];
  int sbit = 0;
  int sess_off = 0;
  bit last_hold = 0;

  always #4 clk = ~clk;

  spi_ucmd_engine i_spi_ucmd_engine (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .spi_cs_n(spi_cs_n)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  endtask

  function automatic logic [7:0] pat_byte(input int b);
    return 8'(b * 29 + 8'h5A);
  endfunction

  function automatic bit pat_bit(input int k);
    logic [7:0] v;
    v = pat_byte(k / 8);
    return v[7 - (k % 8)];
  endfunction

  // slave model: MISO from the pattern stream, MOSI checked against the queue
  always @(negedge spi_cs_n) begin
    sbit = 0;
    spi_miso = pat_bit(0);
  end
  always @(posedge spi_sck) begin
    if (!spi_cs_n) begin
      if (exp_q.size() == 0) begin
        chk(0, "R3 unexpected SCK bit", {31'b0, spi_mosi}, 32'hx);
      end else begin
        bit e;
        e = exp_q.pop_front();
        chk(spi_mosi == e, "R3 MOSI bit", {31'b0, spi_mosi}, {31'b0, e});
      end
      sbit++;
    end
  end
  always @(negedge spi_sck) begin
    if (!spi_cs_n) spi_miso = pat_bit(sbit);
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = 5'(a); bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = 5'(a);
    #1 d = bus_rdata;
    bus_sel = 0;
  endtask

  function automatic logic [31:0] mdl_word(input int w);
    return {mdl[4*w+3], mdl[4*w+2], mdl[4*w+1], mdl[4*w]};
  endfunction

  task automatic load_buf();
    for (int w = 0; w < 16; w++) wr(A_BUF + w, mdl_word(w));
  endtask

  task automatic check_words(input int lo, input int hi, input string tag);
    logic [31:0] d;
    for (int w = lo; w <= hi; w++) begin
      rd(A_BUF + w, d);
      chk(d == mdl_word(w), tag, d, mdl_word(w));
    end
  endtask

  task automatic wait_done();
    logic [31:0] d;
    for (int i = 0; i < 20000; i++) begin
      rd(A_STAT, d);
      if (d[0]) return;
    end
    chk(0, "R5 done never set", d, 32'h1);
  endtask

  // poke: 0 none, 1 writes while busy, 2 measure SCK high phase
  task automatic run_cmd(input int nbits, input bit cap, input bit hold,
                         input int dv, input int poke);
    logic [31:0] d;
    if (!last_hold) sess_off = 0;
    wr(A_CFG, 32'(nbits - 1) | (32'(cap) << 12) | (32'(hold) << 13) | (32'(dv) << 16));
    wr(A_STAT, 32'h0);
    for (int k = 0; k < nbits; k++) exp_q.push_back(mdl[k / 8][7 - (k % 8)]);
    wr(A_CMD, 32'h1);
    if (poke == 1) begin
      rd(A_CMD, d);
      chk(d[0] == 1'b1, "R6 start reads 1 while busy", d, 32'h1);
      wr(A_BUF + 5, 32'hDEAD_BEEF);
      wr(A_CFG, 32'h0000_0003);
      wr(A_CMD, 32'h1);
    end else if (poke == 2) begin
      int n;
      n = 0;
      @(posedge spi_sck);
      forever begin
        @(negedge clk);
        if (spi_sck) n++; else break;
      end
      chk(n == dv + 1, "R10 SCK high phase length", n, dv + 1);
    end
    wait_done();
    chk(exp_q.size() == 0, "R3 bit count", exp_q.size(), 0);
    exp_q.delete();
    chk(spi_cs_n == !hold, "R7 chip select after command", spi_cs_n, !hold);
    if (cap) begin
      for (int k = 0; k < nbits; k++) mdl[k / 8][7 - (k % 8)] = pat_bit(sess_off + k);
    end
    if (hold) sess_off += nbits;
    last_hold = hold;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog expired", 0, 0);
    finish_run();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    @(negedge clk);
    chk(spi_cs_n == 1'b1, "R1 cs_n after reset", spi_cs_n, 1);
    chk(spi_sck == 1'b0, "R1 sck after reset", spi_sck, 0);
    rd(A_CMD, d);  chk(d == 0, "R1 command reg after reset", d, 0);
    rd(A_STAT, d); chk(d == 0, "R1 status reg after reset", d, 0);

    // R2 buffer read-back, little-endian packing
    for (int b = 0; b < 64; b++) mdl[b] = 8'(b * 7 + 3);
    load_buf();
    check_words(0, 15, "R2 buffer read-back");
    wr(A_BUF + 0, 32'h4433_2211);
    mdl[0] = 8'h11; mdl[1] = 8'h22; mdl[2] = 8'h33; mdl[3] = 8'h44;
    check_words(0, 0, "R2 byte 0 in bits 7:0");

    // A: 4 bytes full duplex with busy pokes (R3 R4 R6 R7)
    run_cmd(32, 1, 0, 0, 1);
    check_words(0, 1, "R4 captured data read-back");
    check_words(5, 5, "R6 buffer write while busy ignored");
    rd(A_CFG, d);
    chk(d == 32'h0000_101F, "R6 config write while busy ignored", d, 32'h0000_101F);

    // B: full 64 bytes, capture off, divided clock (R3 R4 R10)
    for (int b = 0; b < 64; b++) mdl[b] = 8'(b * 13 + 1);
    load_buf();
    run_cmd(512, 0, 0, 2, 2);
    check_words(0, 15, "R4 buffer unchanged with capture off");

    // C: 12 bits with chip-select hold, then D: 8 bits releasing (R4 R7)
    run_cmd(12, 1, 1, 0, 0);
    check_words(0, 1, "R4 partial byte capture");
    run_cmd(8, 1, 0, 1, 0);
    check_words(0, 0, "R4 capture continues in held session");

    // R5 done write semantics
    wr(A_STAT, 32'h1);
    rd(A_STAT, d); chk(d[0] == 1'b1, "R5 done kept on write of 1", d, 1);
    wr(A_STAT, 32'h0);
    rd(A_STAT, d); chk(d[0] == 1'b0, "R5 done cleared on write of 0", d, 0);

    // R9 non-master mode blocks start
    wr(A_STAT, 32'h2);
    wr(A_CMD, 32'h1);
    rd(A_CMD, d); chk(d == 0, "R9 start ignored in mode 1", d, 0);
    chk(spi_cs_n == 1'b1, "R9 cs_n stays high", spi_cs_n, 1);
    repeat (10) @(negedge clk);
    rd(A_STAT, d); chk(d[0] == 1'b0, "R9 no completion in mode 1", d, 0);
    wr(A_STAT, 32'h0);

    // R8 abort mid-command
    last_hold = 0;
    wr(A_CFG, 32'h0000_01FF);
    for (int k = 0; k < 512; k++) exp_q.push_back(mdl[k / 8][7 - (k % 8)]);
    wr(A_CMD, 32'h1);
    repeat (20) @(negedge clk);
    wr(A_CMD, 32'h2);
    chk(spi_cs_n == 1'b1, "R8 cs_n after abort", spi_cs_n, 1);
    chk(spi_sck == 1'b0, "R8 sck after abort", spi_sck, 0);
    rd(A_CMD, d); chk(d == 0, "R8 idle after abort", d, 0);
    exp_q.delete();

    // R8 start and reset in the same write: reset wins
    wr(A_CMD, 32'h3);
    rd(A_CMD, d); chk(d == 0, "R8 reset beats start", d, 0);
    repeat (8) @(negedge clk);
    chk(spi_cs_n == 1'b1, "R8 no command after collision", spi_cs_n, 1);

    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule